// File: doc/BRIEF.md
# Clock Synthesizer Divider and Mode Controller

This block holds the digital dividers and the mode steering that sit around a PLL clock synthesizer. A fixed prescaler reduces the oscillator clock by 16 to form the comparison reference. A 9-bit programmable feedback divider sets the loop multiplication. A toggle stage halves the selected source to give a 50% duty output pair. A 2-bit mode input picks between spread and plain PLL operation and two bypass test modes. In the test modes a bidirectional test pin either drives out the prescaled oscillator clock or accepts an external clock that replaces the PLL.

The analog parts are outside the block. The whole controller runs on one fast sampling clock `clk`, and the oscillator and VCO clocks arrive as one-cycle tick enables (`osc_en`, `vco_en`). The test pin is split into an input, an output and an output enable. The feedback divide value enters through a strobe-controlled transparent latch: it follows the input while the strobe is low and freezes on the strobe's rising edge. A master reset input clears the feedback counter and forces the output low without touching the rest of the state.

Top module: `synth_ctrl`

## Requirements
- R1: While `rst_n` is low, `fout` is 0, `fout_n` is 1, `ref_pulse`, `fb_pulse` and `range_err` are 0.
- R2: `ref_pulse` is high for exactly one cycle per 16 `osc_en` ticks, so 160 ticks give 10 pulses.
- R3: In modes 2'b01 and 2'b11 the feedback divider counts `vco_en` ticks. `fb_pulse` occurs once every M ticks, and the first pulse after `mr` is released comes M+1 ticks later.
- R4: While `m_load_n` is low, the divide value follows `m_in` directly. Bit 8 is the most significant bit.
- R5: After `m_load_n` rises, the value sampled in its last low cycle is held, and later `m_in` changes have no effect until the strobe falls again.
- R6: The counter picks up a new divide value only at its terminal count. If the strobe rises in the same cycle as a terminal count, the reload uses the value sampled in the strobe's last low cycle.
- R7: In modes 2'b01 and 2'b11, `fout` toggles once per `vco_en` tick and holds otherwise. `fout_n` is always the inverse of `fout`.
- R8: Mode 2'b00: `test_oe`=1. `test_out` toggles every 8 `osc_en` ticks, and `fout` toggles every 16 ticks. The feedback divider counts prescaler terminal ticks, so its period is 16×M ticks.
- R9: Mode 2'b10: `test_oe`=0. `fout` toggles once per rising edge of `test_in`, after a two-stage synchronizer. `vco_en` is ignored and `fb_pulse` stays 0.
- R10: `spread_en` is 1 only in mode 2'b01. `pll_en` is 1 in modes 2'b01 and 2'b11. `test_oe` is 1 only in mode 2'b00. All three follow `mode` in the same cycle, and a mode change needs no reset.
- R11: `mr` high clears the feedback counter and forces `fout` to 0 and `fout_n` to 1 on the next edge. This takes priority over a `vco_en` tick in the same cycle.
- R12: `range_err` is set when the strobe captures a value below 190 or above 510, and stays set until `rst_n`. 190 and 510 themselves are accepted. The divider still uses the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mr | input | 1 | Master reset: clears feedback counter, forces output low |
| osc_en | input | 1 | Oscillator clock tick |
| vco_en | input | 1 | VCO clock tick |
| m_in | input | 9 | Feedback divide value |
| m_load_n | input | 1 | Latch strobe: low = transparent, rising edge = capture |
| mode | input | 2 | Operating mode select |
| test_in | input | 1 | Test pin input (external clock in mode 2'b10) |
| test_out | output | 1 | Test pin output value |
| test_oe | output | 1 | Test pin output enable |
| fout | output | 1 | True output clock |
| fout_n | output | 1 | Complementary output clock |
| ref_pulse | output | 1 | Reference pulse to the phase comparator |
| fb_pulse | output | 1 | Feedback divider terminal pulse |
| spread_en | output | 1 | Spread modulation enable |
| pll_en | output | 1 | PLL path enable |
| range_err | output | 1 | Sticky flag for a captured divide value outside the lock range |

## Verification
Two events can land in the same cycle. The first is the strobe's rising edge together with the feedback counter's terminal reload. The bench lines up the edge with the predicted terminal tick (M+1 ticks after `mr` release) and puts a different value on `m_in` during the capture cycle. The following pulse interval must then equal the value from the last transparent cycle. The second is a master reset together with a VCO tick: `fout` must read 0 and no feedback pulse may appear, while the next release restarts the M+1 count.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_OSC_TEST   = 2'b00,
    MODE_SPREAD     = 2'b01,
    MODE_EXT_BYPASS = 2'b10,
    MODE_PLAIN      = 2'b11
  } syn_mode_e;
endpackage

// File: rtl/syn_prescale.sv
module syn_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  output logic tick,
  output logic half,
  output logic pulse
);
  localparam int W = $clog2(DIV);

  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_q, pulse_d;

  always_comb begin
    tick    = osc_en && (cnt_q == W'(DIV - 1));
    cnt_d   = cnt_q;
    if (osc_en) cnt_d = tick ? '0 : cnt_q + 1'b1;
    pulse_d = tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign half  = cnt_q[W-1];
  assign pulse = pulse_q;
endmodule

// File: rtl/syn_mlatch.sv
module syn_mlatch #(
  parameter int W     = 9,
  parameter int LO    = 190,
  parameter int HI    = 510
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] m_in,
  input  logic         load_n,
  output logic [W-1:0] m_eff,
  output logic         range_err
);
  logic [W-1:0] m_q, m_d;
  logic         ld_q, err_q, err_d;
  logic         capture, outside;

  always_comb begin
    m_d     = load_n ? m_q : m_in;
    capture = load_n && !ld_q;
    outside = (m_q < W'(LO)) || (m_q > W'(HI));
    err_d   = err_q || (capture && outside);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= W'(LO);
      ld_q  <= 1'b1;
      err_q <= 1'b0;
    end else begin
      m_q   <= m_d;
      ld_q  <= load_n;
      err_q <= err_d;
    end
  end

  assign m_eff     = load_n ? m_q : m_in;
  assign range_err = err_q;
endmodule

// File: rtl/syn_fbdiv.sv
module syn_fbdiv #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] m_val,
  output logic         pulse
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_q, pulse_d;
  logic         at_end;

  always_comb begin
    at_end  = (cnt_q <= W'(1));
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d   = at_end ? m_val : cnt_q - 1'b1;
      pulse_d = (cnt_q == W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/syn_outstage.sv
module syn_outstage
  import synth_ctrl_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  syn_mode_e md,
  input  logic      vco_en,
  input  logic      ref_tick,
  input  logic      test_in,
  output logic      fout
);
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic              prev_q, ext_rise, out_tick;
  logic              fout_q, fout_d;

  generate
    if (SYNC_N == 1) begin : g_sync1
      assign sync_d = test_in;
    end else begin : g_syncn
      assign sync_d = {sync_q[SYNC_N-2:0], test_in};
    end
  endgenerate

  always_comb begin
    ext_rise = sync_q[SYNC_N-1] && !prev_q;
    case (md)
      MODE_OSC_TEST:   out_tick = ref_tick;
      MODE_EXT_BYPASS: out_tick = ext_rise;
      default:         out_tick = vco_en;
    endcase
    if (clr)           fout_d = 1'b0;
    else if (out_tick) fout_d = !fout_q;
    else               fout_d = fout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      fout_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_N-1];
      fout_q <= fout_d;
    end
  end

  assign fout = fout_q;
endmodule

// File: rtl/synth_ctrl.sv
module synth_ctrl
  import synth_ctrl_pkg::*;
#(
  parameter int PRE_DIV = 16,
  parameter int M_W     = 9,
  parameter int M_LO    = 190,
  parameter int M_HI    = 510,
  parameter int SYNC_N  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           osc_en,
  input  logic           vco_en,
  input  logic [M_W-1:0] m_in,
  input  logic           m_load_n,
  input  logic [1:0]     mode,
  input  logic           test_in,
  output logic           test_out,
  output logic           test_oe,
  output logic           fout,
  output logic           fout_n,
  output logic           ref_pulse,
  output logic           fb_pulse,
  output logic           spread_en,
  output logic           pll_en,
  output logic           range_err
);
  logic [1:0]     rst_pipe_q;
  logic           rst_core_n;
  syn_mode_e      md;
  logic           ref_tick, pre_half, fb_tick, fout_q;
  logic [M_W-1:0] m_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign md = syn_mode_e'(mode);

  syn_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_core_n), .osc_en(osc_en),
    .tick(ref_tick), .half(pre_half), .pulse(ref_pulse)
  );

  syn_mlatch #(.W(M_W), .LO(M_LO), .HI(M_HI)) u_mlat (
    .clk(clk), .rst_n(rst_core_n), .m_in(m_in), .load_n(m_load_n),
    .m_eff(m_eff), .range_err(range_err)
  );

  always_comb begin
    case (md)
      MODE_OSC_TEST:   fb_tick = ref_tick;
      MODE_EXT_BYPASS: fb_tick = 1'b0;
      default:         fb_tick = vco_en;
    endcase
  end

  syn_fbdiv #(.W(M_W)) u_fb (
    .clk(clk), .rst_n(rst_core_n), .clr(mr), .tick(fb_tick),
    .m_val(m_eff), .pulse(fb_pulse)
  );

  syn_outstage #(.SYNC_N(SYNC_N)) u_out (
    .clk(clk), .rst_n(rst_core_n), .clr(mr), .md(md), .vco_en(vco_en),
    .ref_tick(ref_tick), .test_in(test_in), .fout(fout_q)
  );

  assign fout      = fout_q;
  assign fout_n    = !fout_q;
  assign test_oe   = (md == MODE_OSC_TEST);
  assign test_out  = test_oe && pre_half;
  assign spread_en = (md == MODE_SPREAD);
  assign pll_en    = (md == MODE_SPREAD) || (md == MODE_PLAIN);
endmodule

// File: rtl/synth_ctrl_chk.sv
module synth_ctrl_chk #(
  parameter int M_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mr,
  input logic           vco_en,
  input logic [1:0]     mode,
  input logic           m_load_n,
  input logic [M_W-1:0] m_eff,
  input logic           fout,
  input logic           ref_pulse,
  input logic           fb_pulse,
  input logic           range_err
);
  assert_ref_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_load_n && $past(m_load_n)) |-> $stable(m_eff));

  assert_fout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && !vco_en && !mr) |=> $stable(fout));

  assert_ext_no_fb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b10) |-> !fb_pulse);

  assert_mr_forces_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> (!fout && !fb_pulse));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err);
endmodule

bind synth_ctrl synth_ctrl_chk #(.M_W(M_W)) u_chk (.*);

// File: tb/tb_synth_ctrl.sv
module tb_synth_ctrl;
  logic       clk, rst_n, mr, osc_en, vco_en, m_load_n, test_in;
  logic [8:0] m_in;
  logic [1:0] mode;
  logic       test_out, test_oe, fout, fout_n, ref_pulse, fb_pulse;
  logic       spread_en, pll_en, range_err;
  int         n_chk, n_bad;
  bit         finished;

  synth_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mr(mr), .osc_en(osc_en), .vco_en(vco_en),
    .m_in(m_in), .m_load_n(m_load_n), .mode(mode), .test_in(test_in),
    .test_out(test_out), .test_oe(test_oe), .fout(fout), .fout_n(fout_n),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .spread_en(spread_en),
    .pll_en(pll_en), .range_err(range_err)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mr = 1'b0; osc_en = 1'b0; vco_en = 1'b0;
    m_in = 9'd200; m_load_n = 1'b0; mode = 2'b11; test_in = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic pulse_mr();
    mr = 1'b1;
    step();
    mr = 1'b0;
  endtask

  task automatic first_fb(output int n);
    n = -1;
    for (int i = 1; i <= 6000; i++) begin
      step();
      if (fb_pulse) begin n = i; break; end
    end
  endtask

  task automatic fb_gap(output int gap);
    int dummy;
    first_fb(dummy);
    first_fb(gap);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vco_en = 1'b1; osc_en = 1'b1; mode = 2'b11; mr = 1'b0;
    m_load_n = 1'b0; m_in = 9'd5; test_in = 1'b0;
    repeat (4) begin
      step();
      chk("R1 fout", fout, 0);
      chk("R1 fout_n", fout_n, 1);
      chk("R1 pulses", {30'd0, ref_pulse, fb_pulse}, 0);
      chk("R1 range_err", range_err, 0);
    end
  endtask

  task automatic t_prescale();
    int cnt = 0;
    do_reset();
    osc_en = 1'b1;
    for (int i = 0; i < 160; i++) begin step(); cnt += int'(ref_pulse); end
    osc_en = 1'b0;
    for (int i = 0; i < 3; i++) begin step(); cnt += int'(ref_pulse); end
    chk("R2 ref pulses per 160 ticks", cnt, 10);
  endtask

  task automatic t_fbdiv(input int m);
    int first, gap;
    do_reset();
    m_in = 9'(m); vco_en = 1'b1;
    pulse_mr();
    first_fb(first);
    chk("R3 first pulse after mr", first, m + 1);
    first_fb(gap);
    chk("R3 pulse period", gap, m);
  endtask

  task automatic t_latch();
    int first, gap;
    do_reset();
    m_in = 9'd300; vco_en = 1'b1;
    pulse_mr();
    first_fb(first);
    chk("R4 transparent first", first, 301);
    first_fb(gap);
    chk("R4 transparent period", gap, 300);
    m_load_n = 1'b1;
    step();
    m_in = 9'd250;
    fb_gap(gap);
    chk("R5 held value ignores m_in", gap, 300);
    m_load_n = 1'b0;
    fb_gap(gap);
    chk("R4 follows again when low", gap, 250);
  endtask

  task automatic t_concurrent();
    int gap;
    do_reset();
    m_in = 9'd200; vco_en = 1'b1;
    pulse_mr();
    for (int i = 1; i <= 199; i++) step();
    m_in = 9'd250;
    step();
    m_load_n = 1'b1; m_in = 9'd511;
    step();
    chk("R6 terminal pulse on strobe edge", fb_pulse, 1);
    first_fb(gap);
    chk("R6 reload from last low cycle", gap, 250);
    chk("R6 no range error for 250", range_err, 0);
  endtask

  task automatic t_outdiv();
    int tog = 0, hi = 0, bad = 0;
    logic prev;
    do_reset();
    prev = fout;
    vco_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step();
      tog += int'(fout != prev); hi += int'(fout); bad += int'(fout_n == fout);
      prev = fout;
    end
    chk("R7 toggles per tick", tog, 40);
    chk("R7 duty high samples", hi, 20);
    chk("R7 fout_n inverse", bad, 0);
    tog = 0;
    for (int i = 0; i < 20; i++) begin
      vco_en = (i % 2 == 0);
      step();
      tog += int'(fout != prev); prev = fout;
    end
    chk("R7 toggles at half rate", tog, 10);
    vco_en = 1'b0; tog = 0;
    for (int i = 0; i < 10; i++) begin step(); tog += int'(fout != prev); prev = fout; end
    chk("R7 hold without tick", tog, 0);
  endtask

  task automatic t_mode00();
    int t_tog = 0, f_tog = 0, gap;
    logic tp, fp;
    do_reset();
    mode = 2'b00;
    #1;
    chk("R8 test_oe", test_oe, 1);
    tp = test_out; fp = fout;
    osc_en = 1'b1;
    for (int i = 0; i < 320; i++) begin
      step();
      t_tog += int'(test_out != tp); f_tog += int'(fout != fp);
      tp = test_out; fp = fout;
    end
    chk("R8 test_out toggles", t_tog, 40);
    chk("R8 fout toggles", f_tog, 20);
    m_in = 9'd4;
    pulse_mr();
    fb_gap(gap);
    chk("R8 feedback period in osc ticks", gap, 64);
  endtask

  task automatic t_mode10();
    int tog = 0, fbc = 0;
    logic prev;
    do_reset();
    mode = 2'b10; vco_en = 1'b1; osc_en = 1'b1;
    #1;
    chk("R9 test_oe", test_oe, 0);
    prev = fout;
    for (int i = 0; i < 10; i++) begin
      step(); tog += int'(fout != prev); fbc += int'(fb_pulse); prev = fout;
    end
    chk("R9 vco ticks ignored", tog, 0);
    for (int e = 0; e < 8; e++) begin
      test_in = 1'b1;
      repeat (2) begin step(); tog += int'(fout != prev); fbc += int'(fb_pulse); prev = fout; end
      test_in = 1'b0;
      repeat (2) begin step(); tog += int'(fout != prev); fbc += int'(fb_pulse); prev = fout; end
    end
    repeat (4) begin step(); tog += int'(fout != prev); fbc += int'(fb_pulse); prev = fout; end
    chk("R9 toggles per test edge", tog, 8);
    chk("R9 feedback idle", fbc, 0);
  endtask

  task automatic t_modes();
    int tog = 0;
    logic prev;
    for (int md = 0; md < 4; md++) begin
      mode = 2'(md);
      #1;
      chk("R10 spread_en", spread_en, int'(md == 1));
      chk("R10 pll_en", pll_en, int'(md == 1 || md == 3));
      chk("R10 test_oe", test_oe, int'(md == 0));
      step();
    end
    do_reset();
    mode = 2'b01; vco_en = 1'b1;
    prev = fout;
    for (int i = 0; i < 20; i++) begin
      if (i == 10) mode = 2'b11;
      step(); tog += int'(fout != prev); prev = fout;
    end
    chk("R10 live switch keeps running", tog, 20);
  endtask

  task automatic t_mr();
    int bad = 0, first;
    do_reset();
    vco_en = 1'b1;
    repeat (5) step();
    mr = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      bad += int'(fout != 1'b0) + int'(fout_n != 1'b1) + int'(fb_pulse);
    end
    chk("R11 held low under mr with ticks", bad, 0);
    mr = 1'b0;
    first_fb(first);
    chk("R11 restart count", first, 201);
  endtask

  task automatic capture(input int v);
    m_load_n = 1'b0; m_in = 9'(v);
    step();
    m_load_n = 1'b1;
    repeat (2) step();
  endtask

  task automatic t_range();
    int gap;
    do_reset();
    m_in = 9'd100;
    step();
    chk("R12 no flag while transparent", range_err, 0);
    capture(190); chk("R12 190 accepted", range_err, 0);
    capture(510); chk("R12 510 accepted", range_err, 0);
    capture(100); chk("R12 100 flagged", range_err, 1);
    vco_en = 1'b1;
    pulse_mr();
    fb_gap(gap);
    chk("R12 divides by captured 100", gap, 100);
    capture(200); chk("R12 sticky", range_err, 1);
    do_reset(); capture(189); chk("R12 189 flagged", range_err, 1);
    do_reset(); capture(511); chk("R12 511 flagged", range_err, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    t_reset();
    t_prescale();
    t_fbdiv(190);
    t_fbdiv(300);
    t_fbdiv(510);
    t_latch();
    t_concurrent();
    t_outdiv();
    t_mode00();
    t_mode10();
    t_modes();
    t_mr();
    t_range();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule